// File: doc/BRIEF.md
# Single-Pulse Push-Button Debouncer

This block takes the raw level of a mechanical push-button and turns each accepted press into one clean pulse, one clock cycle wide. The raw level first passes through a two-flop synchronizer. When the synchronized level first reads high while the controller is idle, the controller does not act at once. It enters a settling state and starts a timer. The press is accepted only if the level is still high on the cycle the timer runs out. Any bouncing before that cycle is ignored.

After an accepted press the controller spends one cycle in a pulse state, with the output high. It then waits in a held state until the button is released. A new press can only begin from idle, so holding the button down never produces a second pulse. The settling length is a parameter counted in clock cycles. Reset is synchronous and active high.

Top module: `press_pulse_gen`

## Requirements
- R1: `sw_raw` is sampled through a two-flop synchronizer. Number clock edges from the first edge that samples `sw_raw` high (edge 0). If the input then stays high, `press_pulse` is high in the cycle that follows edge `SETTLE_CYCLES`+2.
- R2: Low samples of `sw_raw` at any edge from 1 to `SETTLE_CYCLES`-1 do not cancel a press. They also do not move its pulse, as long as the input is high at edge `SETTLE_CYCLES`.
- R3: `press_pulse` is never high for two cycles in a row.
- R4: If `sw_raw` is low at edge `SETTLE_CYCLES`, which is the sample the timer's expiry decides on, no pulse is produced and the controller returns to idle.
- R5: While the button stays pressed after its pulse, no further pulse is produced, however long it is held.
- R6: Once the synchronized input reads low after a pulse, the controller is re-armed. A following press gives a new pulse with the same latency as in R1.
- R7: The settling timer restarts from zero each time the settling state is entered. If a press is rejected at expiry and the input goes high again at edge `SETTLE_CYCLES`+1, the pulse follows edge 2*`SETTLE_CYCLES`+3.
- R8: While `rst` is high, `press_pulse` is low, and the synchronizer, timer and controller are cleared. A press that is held through reset is timed as in R1, from the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_raw | input | 1 | Raw, asynchronous, bouncing switch level; high means pressed |
| press_pulse | output | 1 | One-cycle pulse for each accepted press |

## Verification
The timer's expiry and a change of the switch level can fall on the same cycle, and that cycle decides between accepting the press and returning to idle. The bench provokes this collision by sweeping where the input drops out: at every edge before expiry, exactly at expiry, and just after it. It also places a single-cycle dip exactly on the expiry sample, followed by a re-press. Each case is judged by the count of pulses and the edge on which each pulse appears. The expected edge is computed from the settling length and the two synchronizer stages.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    // Controller states; codes follow the press cycle so each step flips one bit
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_WAIT  = 2'b01,
        ST_PULSE = 2'b11,
        ST_HELD  = 2'b10
    } ppg_state_e;

    // Inputs seen by the next-state function in one cycle
    typedef struct packed {
        logic level;   // synchronized switch level
        logic expire;  // settling timer on its last cycle
    } ppg_obs_t;

    // Counter width needed to count 0 .. n-1 (at least one bit)
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic ppg_state_e next_state(input ppg_state_e cur,
                                              input ppg_obs_t   obs);
        ppg_state_e nxt;
        nxt = cur;
        unique case (cur)
            ST_IDLE:  if (obs.level) nxt = ST_WAIT;
            ST_WAIT:  if (obs.expire) nxt = obs.level ? ST_PULSE : ST_IDLE;
            ST_PULSE: nxt = ST_HELD;
            ST_HELD:  if (!obs.level) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/ppg_sync.sv
module ppg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d_async;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= 1'b0;
            else     chain[g] <= chain[g-1];
        end
    end

    assign q_sync = chain[STAGES-1];

    // R1
    first_stage_follows_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> chain[0] == $past(d_async));

    // R8
    sync_cleared_chk: assert property (@(posedge clk)
        $past(rst) |-> chain == '0);

endmodule

// File: rtl/ppg_timer.sv
module ppg_timer #(
    parameter int unsigned SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int unsigned CW   = ppg_pkg::cnt_width(SETTLE_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign expire = run && (cnt == LAST);

    // R7
    fresh_start_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !$past(run)) |-> cnt == '0);

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R8
    timer_cleared_chk: assert property (@(posedge clk)
        $past(rst) |-> cnt == '0);

endmodule

// File: rtl/ppg_fsm.sv
module ppg_fsm
    import ppg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic expire,
    output logic run,
    output logic pulse
);
    ppg_state_e state;
    ppg_obs_t   obs;

    assign obs.level  = level;
    assign obs.expire = expire;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= next_state(state, obs);
    end

    assign run   = (state == ST_WAIT);
    assign pulse = (state == ST_PULSE);

    // R3
    single_cycle_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    // R2
    pulse_needs_level_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(level) && $past(expire));

    // R4
    reject_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && !level) |=> !pulse && state == ST_IDLE);

    // R5
    stay_held_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HELD && level) |=> state == ST_HELD);

    // R8
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> state == ST_IDLE && !pulse);

endmodule

// File: rtl/press_pulse_gen.sv
module press_pulse_gen #(
    parameter int unsigned SETTLE_CYCLES = 16,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_raw,
    output logic press_pulse
);
    logic level_s;
    logic tmr_run;
    logic tmr_expire;

    ppg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (sw_raw),
        .q_sync  (level_s)
    );

    ppg_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (tmr_run),
        .expire (tmr_expire)
    );

    ppg_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .level  (level_s),
        .expire (tmr_expire),
        .run    (tmr_run),
        .pulse  (press_pulse)
    );

endmodule

// File: tb/sim_press_pulse_gen.sv
module sim_press_pulse_gen;
    localparam int S = 4;
    localparam int N = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sw_raw = 1'b0;
    logic press_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    press_pulse_gen #(.SETTLE_CYCLES(S)) u0 (
        .clk(clk), .rst(rst), .sw_raw(sw_raw), .press_pulse(press_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Raw is high at edge i when i < cut and i != dip, or when i >= p2.
    // Edges are counted from 0; exp_a and exp_b are the edges expected to be
    // followed by a pulse (-1 = none).
    task automatic run_case(input int cut, input int dip, input int p2,
                            input int exp_a, input int exp_b, input string req);
        int npulse = 0;
        int first = -1;
        int second = -1;
        int nexp;
        // settle to idle with the switch released
        repeat (8) @(negedge clk) sw_raw = 1'b0;
        for (int i = 0; i <= N; i++) begin
            @(negedge clk);
            if (press_pulse) begin
                npulse++;
                if (first < 0) first = i - 1;
                else if (second < 0) second = i - 1;
            end
            sw_raw = ((i < cut) && (i != dip)) || (p2 >= 0 && i >= p2);
        end
        nexp = (exp_a >= 0 ? 1 : 0) + (exp_b >= 0 ? 1 : 0);
        check(npulse == nexp, {req, " pulse count"}, npulse, nexp);
        if (exp_a >= 0) check(first == exp_a, {req, " first pulse edge"}, first, exp_a);
        if (exp_b >= 0) check(second == exp_b, {req, " second pulse edge"}, second, exp_b);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : stim
        int hi_seen = 0;
        // R8: output low during and right after reset
        repeat (3) @(negedge clk);
        check(press_pulse == 1'b0, "R8 pulse low in reset", press_pulse, 0);
        rst = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (press_pulse) hi_seen++;
        end
        check(hi_seen == 0, "R8 idle after reset", hi_seen, 0);

        // R1, R3, R5: clean long press, single pulse at edge S+2
        run_case(30, -1, -1, S + 2, -1, "R1 R3 R5 clean long press");

        // R2: a one-cycle dip at every edge inside the settling window
        for (int d = 1; d < S; d++)
            run_case(30, d, -1, S + 2, -1, "R2 bounce inside window");

        // R4: input gone at or before the expiry sample -> no pulse
        for (int c = 1; c <= S; c++)
            run_case(c, -1, -1, -1, -1, "R4 released before expiry");

        // R4 boundary: high through the expiry sample -> accepted
        run_case(S + 1, -1, -1, S + 2, -1, "R4 high through expiry");

        // R7: dip exactly on the expiry sample, then pressed again
        run_case(30, S, -1, 2 * S + 3, -1, "R7 timer restarts");

        // R6: release after pulse then press again at edge 12
        run_case(8, -1, 12, S + 2, 12 + S + 2, "R6 re-arm after release");

        // R8: reset asserted in the middle of a press held throughout
        repeat (8) @(negedge clk) sw_raw = 1'b0;
        @(negedge clk) sw_raw = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(press_pulse == 1'b0, "R8 pulse low in mid-press reset", press_pulse, 0);
        begin
            int first = -1;
            int cnt = 0;
            for (int i = 0; i <= N; i++) begin
                @(negedge clk);
                if (i > 0 && press_pulse) begin
                    cnt++;
                    if (first < 0) first = i - 1;
                end
                if (i == 0) rst = 1'b0;
            end
            check(cnt == 1, "R8 pulses after reset release", cnt, 1);
            check(first == S + 2, "R8 pulse edge after reset", first, S + 2);
        end
        sw_raw = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule